// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns mouse reports into five-byte packets for a serial mouse link and keeps them in an internal byte queue. The host side of a serial channel drains that queue. A report is a one-cycle strobe that carries two signed motion deltas and the state of the left, middle and right buttons. The encoder builds a header byte in which each pressed button pulls its bit low. It then produces a horizontal byte and a vertical byte, and closes with two zero bytes. The vertical axis is sign-inverted, so upward motion comes out positive. Each motion byte is clamped to a symmetric range of plus or minus 127.

Inside the block, a packer hands bytes one per cycle to the queue over a valid/ready link. The queue is 256 entries deep. It always accepts a byte, and it throws the byte away when it already holds 256. While a packet is being emitted, the block raises a busy flag, and any report strobe during that time is ignored. On the read side, the host gets the head byte combinationally and pops it with a read strobe. A flag tells the host whether any byte is waiting.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset the queue is empty: `rd_avail` is 0, `rd_data` is 0x00 and `rpt_busy` is 0.
- R2: The header byte is 0x87 XOR {5'b0, left, middle, right}. Bit 2 is cleared by a pressed left button, bit 1 by middle and bit 0 by right.
- R3: The X byte is `rpt_dx`, read as a signed value and clamped to -127..+127, as 8-bit two's complement. For example, 128 gives 0x7F and -128 gives 0x81.
- R4: The Y byte is the negation of signed `rpt_dy`, clamped to -127..+127. A `rpt_dy` of -32768 gives 0x7F.
- R5: The queue receives each packet's bytes in the order header, X, Y, 0x00, 0x00. The last two bytes are always zero.
- R6: A strobe on `rpt_valid` while `rpt_busy` is 0 is accepted at that clock edge. `rpt_busy` is then 1 for exactly five cycles, one per queued byte. A strobe while `rpt_busy` is 1 adds nothing to the queue.
- R7: The queue returns bytes first in, first out and holds at most 256 of them. A byte that arrives while the queue already holds 256 is discarded.
- R8: When the queue is empty, `rd_data` reads 0x00 and `rd_en` has no effect. `rd_avail` is 1 exactly when at least one byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid | input | 1 | Report strobe |
| rpt_dx | input | 16 | Horizontal delta, signed |
| rpt_dy | input | 16 | Vertical delta, signed |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| rpt_busy | output | 1 | Packet emission in progress; strobes ignored |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte of the queue, 0x00 when empty |
| rd_avail | output | 1 | Queue holds at least one byte |

## Verification
The assertions assume that `rd_en` and `rpt_valid` are single-bit levels sampled at the rising edge. They also assume that the queue level can only rise through packer pushes, which happen only while busy. The stimulus changes every input on the falling edge. It raises reads only between packets, except in the overflow test, which deliberately lets writes run into a full queue. The busy-window property uses a counter in the checker, so its bound of five needs no deep history.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
   localparam int          PKT_BYTES = 5;
   localparam logic [7:0]  HDR_BASE  = 8'h87;
   typedef enum logic [2:0] {
      SLOT_HDR  = 3'd0,
      SLOT_X    = 3'd1,
      SLOT_Y    = 3'd2,
      SLOT_PAD0 = 3'd3,
      SLOT_PAD1 = 3'd4
   } slot_e;
endpackage

// File: rtl/mpe_sat.sv
// Clamp a signed delta (optionally negated) to the symmetric +/-127 range.
module mpe_sat #(
   parameter int W   = 16,
   parameter bit NEG = 1'b0
) (
   input  logic [W-1:0] din,
   output logic [7:0]   dout
);
   localparam int EW = W + 1;
   localparam logic signed [EW-1:0] POS_LIM = EW'(127);
   localparam logic signed [EW-1:0] NEG_LIM = -EW'(127);

   initial begin
      if (W < 8) $error("mpe_sat: W must be at least 8");
   end

   logic signed [EW-1:0] ext;
   logic signed [EW-1:0] val;

   assign ext = {din[W-1], din};

   generate
      if (NEG) begin : g_neg
         assign val = -ext;
      end else begin : g_pos
         assign val = ext;
      end
   endgenerate

   always_comb begin
      if (val > POS_LIM)      dout = 8'h7F;
      else if (val < NEG_LIM) dout = 8'h81;
      else                    dout = val[7:0];
   end
endmodule

// File: rtl/mpe_packer.sv
// Captures one report and streams its five packet bytes over valid/ready.
module mpe_packer
   import mpe_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rpt_valid,
   input  logic [DW-1:0] dx,
   input  logic [DW-1:0] dy,
   input  logic [2:0]    btn,
   output logic          busy,
   output logic          push_valid,
   output logic [7:0]    push_data,
   input  logic          push_ready
);
   logic [7:0] x_sat, y_sat;
   logic [7:0] hdr_q, x_q, y_q;
   logic       active_q;
   slot_e      slot_q;

   mpe_sat #(.W(DW), .NEG(1'b0)) sat_x_i (.din(dx), .dout(x_sat));
   mpe_sat #(.W(DW), .NEG(1'b1)) sat_y_i (.din(dy), .dout(y_sat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         slot_q   <= SLOT_HDR;
         hdr_q    <= HDR_BASE;
         x_q      <= 8'h00;
         y_q      <= 8'h00;
      end else if (!active_q) begin
         if (rpt_valid) begin
            active_q <= 1'b1;
            slot_q   <= SLOT_HDR;
            hdr_q    <= HDR_BASE ^ {5'b0, btn};
            x_q      <= x_sat;
            y_q      <= y_sat;
         end
      end else if (push_ready) begin
         if (slot_q == SLOT_PAD1) begin
            active_q <= 1'b0;
            slot_q   <= SLOT_HDR;
         end else begin
            slot_q   <= slot_e'(slot_q + 3'd1);
         end
      end
   end

   always_comb begin
      unique case (slot_q)
         SLOT_HDR: push_data = hdr_q;
         SLOT_X:   push_data = x_q;
         SLOT_Y:   push_data = y_q;
         default:  push_data = 8'h00;
      endcase
   end

   assign busy       = active_q;
   assign push_valid = active_q;
endmodule

// File: rtl/mpe_fifo.sv
// Byte queue: always ready, drops writes when holding DEPTH bytes, reads 0 when empty.
module mpe_fifo #(
   parameter int DEPTH = 256,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         rd_avail,
   output logic [$clog2(DEPTH):0] level
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

   initial begin
      if (DEPTH < 8 || (1 << AW) != DEPTH)
         $error("mpe_fifo: DEPTH must be a power of two, at least 8");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic [AW:0]   cnt_q;
   logic          do_wr, do_rd;

   assign do_wr = in_valid && (cnt_q != FULL_LVL);
   assign do_rd = rd_en && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr_q] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_wr) wptr_q <= wptr_q + 1'b1;
         if (do_rd) rptr_q <= rptr_q + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign in_ready = 1'b1;
   assign rd_avail = (cnt_q != '0);
   assign rd_data  = rd_avail ? mem[rptr_q] : '0;
   assign level    = cnt_q;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc #(
   parameter int DELTA_W = 16,
   parameter int Q_DEPTH = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rpt_valid,
   input  logic [DELTA_W-1:0] rpt_dx,
   input  logic [DELTA_W-1:0] rpt_dy,
   input  logic               btn_left,
   input  logic               btn_mid,
   input  logic               btn_right,
   output logic               rpt_busy,
   input  logic               rd_en,
   output logic [7:0]         rd_data,
   output logic               rd_avail
);
   localparam int LW = $clog2(Q_DEPTH) + 1;

   logic          push_valid, push_ready;
   logic [7:0]    push_data;
   logic [LW-1:0] q_level;

   mpe_packer #(.DW(DELTA_W)) packer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rpt_valid  (rpt_valid),
      .dx         (rpt_dx),
      .dy         (rpt_dy),
      .btn        ({btn_left, btn_mid, btn_right}),
      .busy       (rpt_busy),
      .push_valid (push_valid),
      .push_data  (push_data),
      .push_ready (push_ready)
   );

   mpe_fifo #(.DEPTH(Q_DEPTH), .W(8)) fifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (push_valid),
      .in_data  (push_data),
      .in_ready (push_ready),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .rd_avail (rd_avail),
      .level    (q_level)
   );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker #(
   parameter int Q_DEPTH = 256
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rpt_valid,
   input logic                       busy,
   input logic                       rd_en,
   input logic [7:0]                 rd_data,
   input logic                       rd_avail,
   input logic [$clog2(Q_DEPTH):0]   level
);
   localparam int LW = $clog2(Q_DEPTH) + 1;
   logic [2:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 3'd1;
      else           run_q <= '0;
   end

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && !busy) |=> busy); // R6
   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < 3'd5)); // R6
   AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(run_q) == 3'd4)); // R6
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_avail |-> (rd_data == 8'h00)); // R8
   AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_avail && !busy) |=> !rd_avail); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(Q_DEPTH)); // R7
   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      level <= $past(level) + 1'b1); // R7
endmodule

bind mouse_pkt_enc mpe_checker #(.Q_DEPTH(Q_DEPTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rpt_valid (rpt_valid),
   .busy      (rpt_busy),
   .rd_en     (rd_en),
   .rd_data   (rd_data),
   .rd_avail  (rd_avail),
   .level     (q_level)
);

// File: tb/mouse_pkt_enc_tb.sv
module mouse_pkt_enc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rpt_valid = 1'b0;
   logic [15:0] rpt_dx = '0, rpt_dy = '0;
   logic        btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
   logic        rpt_busy;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_avail;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mouse_pkt_enc dut_i (
      .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid),
      .rpt_dx(rpt_dx), .rpt_dy(rpt_dy),
      .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
      .rpt_busy(rpt_busy), .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail)
   );

   // {dx, dy, 5'b0, left, mid, right, hdr, xbyte, ybyte}
   localparam int NVEC = 8;
   localparam logic [63:0] VEC [NVEC] = '{
      {16'h0000, 16'h0000, 8'h00, 8'h87, 8'h00, 8'h00},
      {16'h0005, 16'h0003, 8'h04, 8'h83, 8'h05, 8'hFD},
      {16'hFFFB, 16'hFFFD, 8'h02, 8'h85, 8'hFB, 8'h03},
      {16'h007F, 16'hFF81, 8'h01, 8'h86, 8'h7F, 8'h7F},
      {16'h0080, 16'h0080, 8'h07, 8'h80, 8'h7F, 8'h81},
      {16'hFF80, 16'h8000, 8'h05, 8'h82, 8'h81, 8'h7F},
      {16'h7FFF, 16'h7FFF, 8'h00, 8'h87, 8'h7F, 8'h81},
      {16'hFF81, 16'h007F, 8'h03, 8'h84, 8'h81, 8'h81}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] dx, input logic [15:0] dy, input logic [2:0] b);
      @(negedge clk);
      rpt_dx = dx; rpt_dy = dy;
      {btn_left, btn_mid, btn_right} = b;
      rpt_valid = 1'b1;
      @(negedge clk);
      rpt_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (rpt_busy) @(negedge clk);
   endtask

   task automatic pop(input string req, input logic [7:0] exp);
      chk({req, " avail"}, 32'(rd_avail), 32'd1);
      chk(req, 32'(rd_data), 32'(exp));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 avail", 32'(rd_avail), 0);
      chk("R1 data", 32'(rd_data), 0);
      chk("R1 busy", 32'(rpt_busy), 0);

      // Table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         logic [63:0] e;
         e = VEC[v];
         send(e[63:48], e[47:32], e[26:24]);
         for (int c = 0; c < 4; c++) begin
            chk("R6 busy high", 32'(rpt_busy), 1);
            @(negedge clk);
         end
         chk("R6 busy high", 32'(rpt_busy), 1);
         @(negedge clk);
         chk("R6 busy low", 32'(rpt_busy), 0);
         pop("R2 header", e[23:16]);
         pop("R3 xbyte", e[15:8]);
         pop("R4 ybyte", e[7:0]);
         pop("R5 pad0", 8'h00);
         pop("R5 pad1", 8'h00);
         chk("R5 packet length", 32'(rd_avail), 0);
      end

      // R6 strobe while busy is ignored
      send(16'h0011, 16'h0000, 3'b000);
      rpt_dx = 16'h0022; rpt_valid = 1'b1;
      repeat (3) @(negedge clk);
      rpt_valid = 1'b0;
      wait_idle();
      @(negedge clk);
      pop("R6 ignore hdr", 8'h87);
      pop("R6 ignore x", 8'h11);
      pop("R6 ignore y", 8'h00);
      pop("R6 ignore p0", 8'h00);
      pop("R6 ignore p1", 8'h00);
      chk("R6 no extra bytes", 32'(rd_avail), 0);

      // R8 read while empty has no effect
      rd_en = 1'b1;
      repeat (3) @(negedge clk);
      rd_en = 1'b0;
      chk("R8 empty data", 32'(rd_data), 0);
      chk("R8 empty avail", 32'(rd_avail), 0);
      send(16'h0009, 16'h0000, 3'b000);
      wait_idle();
      pop("R8 after empty read", 8'h87);
      pop("R8 after empty read x", 8'h09);
      repeat (3) pop("R8 drain", 8'h00);

      // R7 fill past 256: 52 packets = 260 bytes, last 4 dropped
      for (int p = 0; p < 52; p++) begin
         send(16'(p), 16'h0000, 3'b000);
         wait_idle();
      end
      for (int i = 0; i < 256; i++) begin
         logic [7:0] x;
         case (i % 5)
            0: x = 8'h87;
            1: x = 8'(i / 5);
            default: x = 8'h00;
         endcase
         pop("R7 fifo order", x);
      end
      chk("R7 overflow dropped", 32'(rd_avail), 0);
      chk("R8 empty after drain", 32'(rd_data), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule